// File: doc/BRIEF.md
# Character Display Output Port

This block is a polled or interrupt-driven output port for a processor that reaches peripherals through ordinary loads and stores on a 16-bit bus. Software places one character at a time on the display side. It does this by storing to a data register. Before each store it checks a ready flag in a status register, or it lets an interrupt request tell it that the port is free.

A store to the data register while the port is free latches the low byte of the store data. The port then raises a valid strobe toward the display sink and drops the ready flag. The sink keeps the character for as long as it needs and then pulses a done signal. One clock later the port is ready again. Stores to the data register that arrive while the port is busy are dropped without any effect. The status register also holds a writable interrupt-enable bit. The interrupt request is the AND of that bit and the ready flag.

Top module: `char_disp_port`

## Requirements
- R1: After reset the ready flag (status bit 15) is 1, the interrupt enable (status bit 14) is 0, disp_valid_o is 0, disp_char_o is 0 and irq_o is 0.
- R2: The status register decodes only at address 16'hFE04 and the data register only at 16'hFE06. A store to any other address changes nothing, and a read of any other address returns 16'h0000.
- R3: A store to 16'hFE06 while ready is 1 takes effect at that clock edge. From then on disp_char_o equals store data bits [7:0], disp_valid_o is 1 and the ready flag is 0.
- R4: A store to 16'hFE06 while ready is 0 is ignored, and disp_char_o keeps its value.
- R5: When disp_done_i is high at a clock edge while a character is pending, the ready flag is 1 and disp_valid_o is 0 after that edge. When no character is pending, disp_done_i has no effect.
- R6: irq_o is 1 exactly when the ready flag and the interrupt enable are both 1.
- R7: A store to 16'hFE04 loads the interrupt enable from store data bit 14. The ready flag cannot be written.
- R8: A read of 16'hFE04 returns {ready, interrupt enable, 14'b0}. The read is combinational on addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Bus address |
| we_i | input | 1 | Store strobe, one cycle per store |
| wdata_i | input | 16 | Store data |
| rdata_o | output | 16 | Read data for addr_i |
| disp_char_o | output | 8 | Character presented to the sink |
| disp_valid_o | output | 1 | Character pending at the sink |
| disp_done_i | input | 1 | Sink finished with the character |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that we_i is a clean single-cycle strobe sampled with a stable addr_i and wdata_i. They also assume that disp_done_i means something only while a character is pending. The assertions still allow done to arrive while the port is idle, and the bench does this on purpose. The stimulus changes every input on the falling clock edge and holds it through the next rising edge. Each bus operation lasts exactly one cycle, and done is pulsed for a single cycle, so every property sees one well-defined event per edge.

// File: rtl/char_disp_pkg.sv
package char_disp_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned CHAR_W = 8;
  localparam logic [BUS_W-1:0] STAT_ADDR = 16'hFE04;
  localparam logic [BUS_W-1:0] DATA_ADDR = 16'hFE06;
  localparam int unsigned RDY_BIT = 15;
  localparam int unsigned IE_BIT  = 14;
endpackage

// File: rtl/char_disp_dec.sv
module char_disp_dec
  import char_disp_pkg::*;
#(
  parameter int unsigned AW = BUS_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  output logic          stat_sel_o,
  output logic          stat_we_o,
  output logic          data_we_o
);
  always_comb begin
    stat_sel_o = (addr_i == STAT_ADDR[AW-1:0]);
    stat_we_o  = we_i && stat_sel_o;
    data_we_o  = we_i && (addr_i == DATA_ADDR[AW-1:0]);
  end
endmodule

// File: rtl/char_disp_stat.sv
module char_disp_stat
  import char_disp_pkg::*;
#(
  parameter int unsigned DW = BUS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stat_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          accept_i,
  input  logic          release_i,
  output logic          ready_o,
  output logic          ie_o,
  output logic          irq_o
);
  logic ready_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b1;
      ie_q    <= 1'b0;
    end else begin
      if (stat_we_i) ie_q <= wdata_i[IE_BIT];
      if (accept_i)       ready_q <= 1'b0;
      else if (release_i) ready_q <= 1'b1;
    end
  end

  assign ready_o = ready_q;
  assign ie_o    = ie_q;
  assign irq_o   = ready_q & ie_q;

  p_ie_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i |=> ie_q == $past(wdata_i[IE_BIT]));
  p_ready_fixed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && !accept_i && !release_i) |=> $stable(ready_q));
  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i && !accept_i) |=> ready_q);
endmodule

// File: rtl/char_disp_chan.sv
module char_disp_chan
  import char_disp_pkg::*;
#(
  parameter int unsigned DW = BUS_W,
  parameter int unsigned CW = CHAR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          data_we_i,
  input  logic          ready_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          done_i,
  output logic          accept_o,
  output logic          release_o,
  output logic [CW-1:0] char_o,
  output logic          valid_o
);
  logic [CW-1:0] char_q;
  logic          valid_q;

  assign accept_o  = data_we_i && ready_i;
  assign release_o = done_i && valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (accept_o) begin
        char_q  <= wdata_i[CW-1:0];
        valid_q <= 1'b1;
      end else if (release_o) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign char_o  = char_q;
  assign valid_o = valid_q;

  p_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && ready_i) |=> valid_q && char_q == $past(wdata_i[CW-1:0]));
  p_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !ready_i) |=> $stable(char_q));
  p_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && valid_q && !data_we_i) |=> !valid_q);
endmodule

// File: rtl/char_disp_port.sv
module char_disp_port
  import char_disp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  addr_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [CHAR_W-1:0] disp_char_o,
  output logic              disp_valid_o,
  input  logic              disp_done_i,
  output logic              irq_o
);
  logic stat_sel, stat_we, data_we;
  logic accept, release_ev, ready, ie;

  char_disp_dec #(.AW(BUS_W)) i_dec (
    .addr_i    (addr_i),
    .we_i      (we_i),
    .stat_sel_o(stat_sel),
    .stat_we_o (stat_we),
    .data_we_o (data_we)
  );

  char_disp_stat #(.DW(BUS_W)) i_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stat_we_i(stat_we),
    .wdata_i  (wdata_i),
    .accept_i (accept),
    .release_i(release_ev),
    .ready_o  (ready),
    .ie_o     (ie),
    .irq_o    (irq_o)
  );

  char_disp_chan #(.DW(BUS_W), .CW(CHAR_W)) i_chan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_we_i(data_we),
    .ready_i  (ready),
    .wdata_i  (wdata_i),
    .done_i   (disp_done_i),
    .accept_o (accept),
    .release_o(release_ev),
    .char_o   (disp_char_o),
    .valid_o  (disp_valid_o)
  );

  // status readback mux
  always_comb begin
    rdata_o = '0;
    if (stat_sel) begin
      rdata_o[RDY_BIT] = ready;
      rdata_o[IE_BIT]  = ie;
    end
  end

  p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready && disp_valid_o));
  p_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == STAT_ADDR) |-> irq_o == (rdata_o[RDY_BIT] && rdata_o[IE_BIT]));
  p_rd_other_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != STAT_ADDR) |-> rdata_o == '0);
  p_rd_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[IE_BIT-1:0] == '0);
endmodule

// File: tb/test_char_disp_port.sv
module test_char_disp_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        we = 1'b0;
  logic [15:0] wdata = 16'h0000;
  logic        done = 1'b0;
  logic [15:0] rdata;
  logic [7:0]  dchar;
  logic        dvalid;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  char_disp_port i_char_disp_port (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .addr_i      (addr),
    .we_i        (we),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .disp_char_o (dchar),
    .disp_valid_o(dvalid),
    .disp_done_i (done),
    .irq_o       (irq)
  );

  // {done, addr, wdata, exp_stat, exp_char, exp_valid, exp_irq}
  localparam int NV = 12;
  localparam logic [58:0] VEC [NV] = '{
    {1'b0, 16'hFE04, 16'h4000, 16'hC000, 8'h00, 1'b0, 1'b1}, // R7 R6
    {1'b0, 16'hFE06, 16'h0141, 16'h4000, 8'h41, 1'b1, 1'b0}, // R3
    {1'b0, 16'hFE06, 16'h0042, 16'h4000, 8'h41, 1'b1, 1'b0}, // R4
    {1'b1, 16'h0000, 16'h0000, 16'hC000, 8'h41, 1'b0, 1'b1}, // R5
    {1'b1, 16'h0000, 16'h0000, 16'hC000, 8'h41, 1'b0, 1'b1}, // R5 idle
    {1'b0, 16'hFE06, 16'hFF5A, 16'h4000, 8'h5A, 1'b1, 1'b0}, // R3
    {1'b0, 16'hFE04, 16'h8000, 16'h0000, 8'h5A, 1'b1, 1'b0}, // R7
    {1'b0, 16'hFE02, 16'h4063, 16'h0000, 8'h5A, 1'b1, 1'b0}, // R2
    {1'b1, 16'h0000, 16'h0000, 16'h8000, 8'h5A, 1'b0, 1'b0}, // R5
    {1'b0, 16'hFE05, 16'h4077, 16'h8000, 8'h5A, 1'b0, 1'b0}, // R2
    {1'b0, 16'hFE07, 16'h4031, 16'h8000, 8'h5A, 1'b0, 1'b0}, // R2
    {1'b0, 16'hFE06, 16'h0031, 16'h0000, 8'h31, 1'b1, 1'b0}  // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle operation; inputs change on the falling edge
  task automatic do_op(input logic d, input logic [15:0] a, input logic [15:0] w);
    @(negedge clk);
    done = d; addr = a; wdata = w; we = ~d;
    @(negedge clk);
    done = 1'b0; we = 1'b0; addr = 16'hFE04;
    #1;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    addr = 16'hFE04;
    #1;
    check("R1 status", 32'(rdata), 32'h8000);
    check("R1 valid", 32'(dvalid), 32'h0);
    check("R1 char", 32'(dchar), 32'h00);
    check("R1 irq", 32'(irq), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][58], VEC[i][57:42], VEC[i][41:26]);
      check("R8 status vec", 32'(rdata), 32'(VEC[i][25:10]));
      check("R3 char vec", 32'(dchar), 32'(VEC[i][9:2]));
      check("R5 valid vec", 32'(dvalid), 32'(VEC[i][1]));
      check("R6 irq vec", 32'(irq), 32'(VEC[i][0]));
    end

    // R2: non-status read returns zero
    addr = 16'hFE06;
    #1;
    check("R2 read data addr", 32'(rdata), 32'h0);
    addr = 16'hFE04;

    // R4: a burst of stores while busy keeps the first character
    do_op(1'b0, 16'hFE06, 16'h00AA);
    do_op(1'b0, 16'hFE06, 16'h00BB);
    check("R4 busy burst", 32'(dchar), 32'h31);

    // R1: asynchronous reset while busy
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset busy status", 32'(rdata), 32'h8000);
    check("R1 reset busy valid", 32'(dvalid), 32'h0);
    check("R1 reset busy char", 32'(dchar), 32'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: store immediately after release is accepted
    do_op(1'b0, 16'hFE06, 16'h0010);
    do_op(1'b1, 16'h0000, 16'h0000);
    do_op(1'b0, 16'hFE06, 16'h0020);
    check("R3 back to back", 32'(dchar), 32'h20);
    check("R3 ready low", 32'(rdata), 32'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule